// File: doc/BRIEF.md
# Static Control-Word Sequencer with Demonstration Datapath

This block steps through a small memory of wide control words and applies each one, bit for bit, to a datapath for exactly one clock cycle. No opcode exists and nothing is decoded. Every multiplexer select, register write enable and operator choice for a cycle sits in its own field of the stored word. All scheduling, ordering and hazard avoidance is settled offline when the words are written. Several independent transfers can therefore share one cycle simply because one word enables them together.

A testbench or host writes the words through a plain write port while the block is idle, then pulses `start`. The sequencer fetches address 0 and moves through the program, either to the next address or to an absolute jump target. It stops at the first word whose stop bit is set and signals completion for one cycle. The attached demonstration datapath has four 16-bit registers, two read multiplexers and an add/subtract/pass/load operator. A bench can observe real results through the flattened register view, and the applied control word is also exported on `ctrlBus`.

Top module: `cw_engine_top`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0, `ctrlBus` is 0 and every register in `regView` reads 0.
- R2: A `start` pulse sampled while idle launches a run. In the following cycle `busy` is 1 and `ctrlBus` shows the word stored at address 0, and that word's register writes land on the next clock edge (one cycle of fetch latency).
- R3: After a word with both stop and jump bits clear, the next applied word is the one at the following address, wrapping from address 31 to address 0.
- R4: After a word with the jump bit set and the stop bit clear, the next applied word is the one at the absolute target held in that word. The words in between are never applied.
- R5: A word with the stop bit set is still applied in full. On the edge that retires it, `busy` falls and `done` rises, and `done` stays high for exactly one cycle.
- R6: While idle, `ctrlBus` is all zero, no register write enable is active and every register holds its value.
- R7: A `start` pulse while busy is ignored, and the program continues along its scheduled path.
- R8: Operator field encoding: 0 writes A+B (modulo 2^16), 1 writes A−B (modulo 2^16), 2 writes A, 3 writes the `dataIn` value sampled at the write edge. A and B are the registers picked by the two select fields.
- R9: Every register whose enable bit is set in a word takes the same result on that edge. Operands are read from the values held before the edge.
- R10: Control word layout, LSB first: bits 3:0 are the per-register write enables (bit i for register i), bits 5:4 select A, bits 7:6 select B, bits 9:8 hold the operator, bits 14:10 the jump target, bit 15 the jump bit and bit 16 the stop bit. Register i appears in `regView` bits 16i+15 down to 16i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, honoured only while idle |
| cwWrEn | input | 1 | Control memory write strobe |
| cwWrAddr | input | 5 | Control memory write address |
| cwWrData | input | 17 | Control word to store |
| dataIn | input | 16 | External operand used by the load operator |
| busy | output | 1 | High while a program is running |
| done | output | 1 | One-cycle completion pulse |
| ctrlBus | output | 17 | Control word currently applied, zero when idle |
| regView | output | 64 | All four datapath registers, flattened |

## Verification
The bench targets the fetch latency at launch. A design one cycle early or late would show the wrong word on `ctrlBus` and corrupt every register result. It checks that a taken jump never exposes the skipped words, which a design with a hidden delay slot would apply. It also checks address wrap from 31 to 0, which would break with a mis-sized program counter. It checks that the stop word still performs its writes and that `done` lasts one cycle, a restart issued during that very cycle, a start pulse ignored mid-run, and a multi-register write whose operands must come from the pre-edge values.

// File: rtl/cw_engine_pkg.sv
package cw_engine_pkg;
  localparam int DATA_W    = 16;
  localparam int NUM_REGS  = 4;
  localparam int REG_IDX_W = $clog2(NUM_REGS);
  localparam int ADDR_W    = 5;
  localparam int DEPTH     = 1 << ADDR_W;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_PASS = 2'd2,
    OP_LOAD = 2'd3
  } op_e;

  // Field order fixes the bit layout (MSB first).
  typedef struct packed {
    logic                 stop;
    logic                 jump;
    logic [ADDR_W-1:0]    target;
    op_e                  opSel;
    logic [REG_IDX_W-1:0] selB;
    logic [REG_IDX_W-1:0] selA;
    logic [NUM_REGS-1:0]  wrEn;
  } ctrl_word_t;

  // Strobes handed from the sequencer to the datapath.
  typedef struct packed {
    logic [NUM_REGS-1:0]  wrEn;
    logic [REG_IDX_W-1:0] selA;
    logic [REG_IDX_W-1:0] selB;
    op_e                  opSel;
  } dp_strobe_t;

  localparam int CW_W = $bits(ctrl_word_t);
endpackage

// File: rtl/cw_sequencer.sv
module cw_sequencer
  import cw_engine_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    cwWrEn,
  input  logic [ADDR_W-1:0]       cwWrAddr,
  input  logic [CW_W-1:0]         cwWrData,
  output logic                    busy,
  output logic                    done,
  output logic [CW_W-1:0]         ctrlBus,
  output dp_strobe_t              strobe
);
  ctrl_word_t        cwMem [DEPTH];
  ctrl_word_t        cwQ;
  logic [ADDR_W-1:0] pcQ;
  logic              activeQ;
  logic              doneQ;

  logic              launch;
  logic              advance;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] fetchAddr;

  always_comb begin
    launch    = !activeQ && start;
    advance   = activeQ && !cwQ.stop;
    nextAddr  = cwQ.jump ? cwQ.target : ADDR_W'(pcQ + 1'b1);
    fetchAddr = launch ? '0 : nextAddr;
  end

  always_ff @(posedge clk) begin
    if (cwWrEn) cwMem[cwWrAddr] <= ctrl_word_t'(cwWrData);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      activeQ <= 1'b0;
      doneQ   <= 1'b0;
      pcQ     <= '0;
      cwQ     <= '0;
    end else begin
      doneQ <= activeQ && cwQ.stop;
      if (launch || advance) begin
        cwQ <= cwMem[fetchAddr];
        pcQ <= fetchAddr;
      end
      if (launch) activeQ <= 1'b1;
      else if (activeQ && cwQ.stop) activeQ <= 1'b0;
    end
  end

  always_comb begin
    strobe.wrEn  = activeQ ? cwQ.wrEn : '0;
    strobe.selA  = cwQ.selA;
    strobe.selB  = cwQ.selB;
    strobe.opSel = cwQ.opSel;
    ctrlBus      = activeQ ? CW_W'(cwQ) : '0;
    busy         = activeQ;
    done         = doneQ;
  end

  // R2
  launch_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (!activeQ && start) |=> (activeQ && pcQ == '0));

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (activeQ && !cwQ.stop && !cwQ.jump) |=> (pcQ == ADDR_W'($past(pcQ) + 1'b1)));

  // R4
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    (activeQ && !cwQ.stop && cwQ.jump) |=> (pcQ == $past(cwQ.target)));

  // R5
  stop_retire_chk: assert property (@(posedge clk) disable iff (rst)
    (activeQ && cwQ.stop) |=> (!activeQ && doneQ));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> !doneQ);
endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
  import cw_engine_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  dp_strobe_t                 strobe,
  input  logic [DATA_W-1:0]          dataIn,
  output logic [NUM_REGS*DATA_W-1:0] regView
);
  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [DATA_W-1:0] opA;
  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] result;

  always_comb begin
    opA = regFile[strobe.selA];
    opB = regFile[strobe.selB];
    unique case (strobe.opSel)
      OP_ADD:  result = opA + opB;
      OP_SUB:  result = opA - opB;
      OP_PASS: result = opA;
      default: result = dataIn;
    endcase
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rst)                 regFile[i] <= '0;
      else if (strobe.wrEn[i]) regFile[i] <= result;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_view
    assign regView[g*DATA_W +: DATA_W] = regFile[g];
  end

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.wrEn == '0) |=> $stable(regView));

  // R8
  load_path_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.wrEn[0] && strobe.opSel == OP_LOAD) |=> (regView[DATA_W-1:0] == $past(dataIn)));
endmodule

// File: rtl/cw_engine_top.sv
module cw_engine_top
  import cw_engine_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       cwWrEn,
  input  logic [ADDR_W-1:0]          cwWrAddr,
  input  logic [CW_W-1:0]            cwWrData,
  input  logic [DATA_W-1:0]          dataIn,
  output logic                       busy,
  output logic                       done,
  output logic [CW_W-1:0]            ctrlBus,
  output logic [NUM_REGS*DATA_W-1:0] regView
);
  dp_strobe_t strobe;

  cw_sequencer u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cwWrEn   (cwWrEn),
    .cwWrAddr (cwWrAddr),
    .cwWrData (cwWrData),
    .busy     (busy),
    .done     (done),
    .ctrlBus  (ctrlBus),
    .strobe   (strobe)
  );

  cw_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .regView (regView)
  );
endmodule

// File: tb/cw_engine_top_test.sv
module cw_engine_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        cwWrEn = 1'b0;
  logic [4:0]  cwWrAddr = '0;
  logic [16:0] cwWrData = '0;
  logic [15:0] dataIn = 16'h1234;
  logic        busy, done;
  logic [16:0] ctrlBus;
  logic [63:0] regView;

  always #5 clk = ~clk;

  cw_engine_top uut (
    .clk(clk), .rst(rst), .start(start), .cwWrEn(cwWrEn), .cwWrAddr(cwWrAddr),
    .cwWrData(cwWrData), .dataIn(dataIn), .busy(busy), .done(done),
    .ctrlBus(ctrlBus), .regView(regView)
  );

  int checks = 0;
  int errors = 0;
  bit cmpOn = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R10 layout built independently of the RTL
  function automatic logic [16:0] mkcw(input bit stopB, input bit jumpB, input int tgt,
                                       input int op, input int sa, input int sb, input int wr);
    return {stopB, jumpB, tgt[4:0], op[1:0], sb[1:0], sa[1:0], wr[3:0]};
  endfunction

  // behavioural reference model
  logic [16:0] mMem [32];
  logic [15:0] mReg [4];
  logic        mActive = 0;
  logic        mDone = 0;
  int          mPc = 0;
  logic [16:0] mw;
  logic [15:0] ma, mb, mr;
  bit          nd;

  always @(posedge clk) begin
    if (rst) begin
      mActive = 0; mDone = 0; mPc = 0;
      for (int i = 0; i < 4; i++) mReg[i] = '0;
    end else begin
      nd = 0;
      if (mActive) begin
        mw = mMem[mPc];
        ma = mReg[mw[5:4]];
        mb = mReg[mw[7:6]];
        case (mw[9:8])
          2'd0: mr = ma + mb;
          2'd1: mr = ma - mb;
          2'd2: mr = ma;
          default: mr = dataIn;
        endcase
        for (int i = 0; i < 4; i++) if (mw[i]) mReg[i] = mr;
        if (mw[16]) begin mActive = 0; nd = 1; end
        else if (mw[15]) mPc = int'(mw[14:10]);
        else mPc = (mPc + 1) % 32;
      end else if (start) begin
        mActive = 1; mPc = 0;
      end
      mDone = nd;
    end
    if (cwWrEn) mMem[cwWrAddr] = cwWrData;
  end

  logic [16:0] expBus;
  always @(negedge clk) begin
    if (cmpOn && !rst) begin
      expBus = mActive ? mMem[mPc] : '0;
      chk(busy == mActive, "R2 busy", 64'(busy), 64'(mActive));
      chk(done == mDone, "R5 done", 64'(done), 64'(mDone));
      chk(ctrlBus == expBus, mActive ? "R3 ctrlBus" : "R6 ctrlBus", 64'(ctrlBus), 64'(expBus));
      chk(regView == {mReg[3], mReg[2], mReg[1], mReg[0]}, "R8 regView",
          regView, {mReg[3], mReg[2], mReg[1], mReg[0]});
    end
  end

  task automatic tick();
    @(negedge clk);
    dataIn = dataIn * 16'd25173 + 16'd13849;
  endtask

  task automatic writeWord(input int addr, input logic [16:0] w);
    cwWrEn = 1'b1; cwWrAddr = addr[4:0]; cwWrData = w;
    tick();
    cwWrEn = 1'b0;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [63:0] held;
  logic [16:0] w0, w1, w2, w3, w4, w8, w9, wStop;

  initial begin
    w0 = mkcw(0, 0, 0, 3, 0, 0, 4'b0001);
    w1 = mkcw(0, 0, 0, 3, 0, 0, 4'b0010);
    w2 = mkcw(0, 0, 0, 0, 0, 1, 4'b0100);
    w3 = mkcw(0, 0, 0, 1, 0, 1, 4'b1000);
    w4 = mkcw(0, 1, 8, 2, 2, 0, 4'b0010);
    w8 = mkcw(0, 0, 0, 0, 0, 0, 4'b0101);
    w9 = mkcw(1, 0, 0, 1, 3, 1, 4'b0010);
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk(busy == 0 && done == 0, "R1 flags", {busy, done}, 0);
    chk(ctrlBus == 0, "R1 ctrlBus", 64'(ctrlBus), 0);
    chk(regView == 0, "R1 regView", regView, 0);
    cmpOn = 1;

    for (int a = 0; a < 32; a++) writeWord(a, mkcw(0, 0, 0, 3, 0, 0, 4'b0000));
    writeWord(0, w0); writeWord(1, w1); writeWord(2, w2); writeWord(3, w3); writeWord(4, w4);
    for (int a = 5; a < 8; a++) writeWord(a, mkcw(0, 0, 0, 3, 0, 0, 4'b1111));
    writeWord(8, w8); writeWord(9, w9);

    // R6 idle hold
    held = regView;
    repeat (4) tick();
    chk(regView == held, "R6 idle hold", regView, held);

    // program 1
    start = 1'b1; tick(); start = 1'b0;
    chk(busy && ctrlBus == w0, "R2 launch word", 64'(ctrlBus), 64'(w0));
    start = 1'b1; tick(); start = 1'b0;
    tick();
    chk(ctrlBus == w2, "R7 start ignored", 64'(ctrlBus), 64'(w2));
    tick(); tick();
    chk(ctrlBus[15] == 1'b1 && ctrlBus[14:10] == 5'd8, "R10 jump fields", 64'(ctrlBus), 64'(w4));
    tick();
    chk(ctrlBus == w8, "R4 jump landing", 64'(ctrlBus), 64'(w8));
    tick();
    chk(regView[15:0] == regView[47:32], "R9 shared write", 64'(regView[15:0]), 64'(regView[47:32]));
    chk(ctrlBus == w9, "R10 stop word", 64'(ctrlBus), 64'(w9));
    tick();
    chk(!busy && done, "R5 stop retire", {busy, done}, 64'b01);
    // restart during the done cycle
    start = 1'b1; tick(); start = 1'b0;
    chk(busy && !done && ctrlBus == w0, "R5 done one cycle", {busy, done}, 64'b10);
    repeat (8) tick();
    chk(!busy && !done && ctrlBus == 0, "R6 idle bus", 64'(ctrlBus), 0);

    // program 2: wrap from 31 to 0
    writeWord(0, mkcw(0, 1, 29, 0, 0, 0, 4'b0000));
    writeWord(29, mkcw(0, 0, 0, 3, 0, 0, 4'b0100));
    writeWord(30, mkcw(0, 0, 0, 2, 2, 0, 4'b1000));
    writeWord(31, mkcw(0, 0, 0, 1, 3, 2, 4'b0010));
    wStop = mkcw(1, 0, 0, 0, 1, 1, 4'b0001);
    start = 1'b1; tick(); start = 1'b0;
    tick();
    cwWrEn = 1'b1; cwWrAddr = 5'd0; cwWrData = wStop;
    tick();
    cwWrEn = 1'b0;
    tick();
    chk(ctrlBus[16:0] == mkcw(0, 0, 0, 1, 3, 2, 4'b0010), "R3 last address", 64'(ctrlBus), 0);
    tick();
    chk(ctrlBus == wStop, "R3 wrap to zero", 64'(ctrlBus), 64'(wStop));
    tick();
    chk(done && regView[31:16] == 16'd0, "R8 sub result", 64'(regView[31:16]), 0);
    repeat (3) tick();

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule